// File: doc/BRIEF.md
# Interrupt Aggregator with Coalescing

This block gathers interrupt causes for a host-attached device and presents them on one level-sensitive interrupt line. Hardware sources raise single-cycle event pulses that set sticky bits in a 32-bit primary status register. A second 32-bit register holds the status of the bus-master DMA side. Its receive, transmit and error bits are folded into three summary bits of the primary register. The host enables causes through a mask register and acknowledges them by writing ones to the status registers.

To limit the host's interrupt load, a coalescing timer holds the line low for a programmable number of 32-microsecond units after the first unmasked cause appears. A high-priority DMA receive event skips that delay. A separate periodic timer sets a receive-poll status bit at a programmable interval. Time is supplied as a one-cycle `tick_us` pulse per microsecond. Register reads are combinational from `rd_sel`, and writes take effect on the clock edge where `wr_en` is high.

Top module: `irq_aggregator`

## Requirements
- R1: The direct primary status bits (positions 26, 25, 7, 6, 3, 1, 0) are set by a `src_evt` pulse at that position. They stay set until the host writes 1 to that position of register 0 (`wr_sel`=0); writing 0 leaves them unchanged.
- R2: When a set and a host clear reach the same status bit on the same edge, the bit ends up set.
- R3: DMA status (register 2) implements bits 31, 30, 17, 16, 1, 0. These are set by `dma_evt` and cleared by writing 1 to register 2. Every other DMA bit reads 0. The readable primary bits are 31, 29, 28, 27, 26, 25, 7, 6, 3, 1 and 0; all other primary bits read 0.
- R4: Primary bits are derived from DMA status as follows, and a write to these positions of register 0 does not change them:
  - bit 31 is the OR of DMA bits 17, 16 and 30;
  - bit 29 equals DMA bit 31;
  - bit 27 is the OR of DMA bits 1 and 0.
- R5: Register 1 is a read/write mask. `irq` is low whenever no primary bit is set together with its mask bit.
- R6: The coalescing length C is register 3 bits 7:0. With C=0, `irq` is high whenever an unmasked bit is pending. With C>0, a window starts on the first edge at which an unmasked bit is pending while the timer is idle. `irq` then stays low until C×32 `tick_us` pulses have been sampled on later edges, and goes high on the edge that samples the last of them.
- R7: A host write of nonzero data to register 0 or 2, or the loss of every pending unmasked bit, returns the timer to idle and closes the window. A cause still pending then starts a fresh window.
- R8: When DMA bit 30 is set and mask bit 31 is set, `irq` is high regardless of the coalescing window.
- R9: The periodic length P is register 3 bits 15:8. With P≠0, primary bit 28 is set once every P×32 `tick_us` pulses. With P=0, bit 28 is never set.
- R10: After reset all registers read 0 and `irq` is low.
- R11: Register 3 reads back bits 15:0 as written, with upper bits 0. Register 1 reads back all 32 bits as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | 32 | Event pulses for the direct primary bits |
| dma_evt | input | 32 | Event pulses for the DMA status bits |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select: 0 primary, 1 mask, 2 DMA, 3 timing |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select, same encoding |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Level interrupt to the host |

## Verification
The assertions assume that inputs are synchronous to `clk` and stable around each edge, and that reset is held for at least one edge at start-up. The bench meets this by driving every input a fixed delay after the rising edge. The window assertions also take `tick_us` as a free pulse train that may be high on any edge. The bench therefore drives it continuously high in the directed timing phases and at random in the mixed phase. Register 3 is limited there to small lengths so that windows open and close many times within the run.

// File: rtl/irq_pkg.sv
// Shared constants and types for the interrupt aggregator.
// Assumes a 32-bit register width; bit positions are fixed by the decode.
package irq_pkg;
    localparam int DATA_W = 32;

    // Primary positions set directly by hardware sources.
    localparam logic [DATA_W-1:0] DIRECT_BITS  = 32'h0600_00CB;
    localparam int                POLL_POS     = 28;
    localparam logic [DATA_W-1:0] PRIM_STICKY  = DIRECT_BITS | (32'h1 << POLL_POS);
    // Primary summary positions derived from DMA status.
    localparam int                RX_SUM_POS   = 31;
    localparam int                ERR_SUM_POS  = 29;
    localparam int                TX_SUM_POS   = 27;
    // DMA status positions.
    localparam logic [DATA_W-1:0] DMA_BITS     = 32'hC003_0003;
    localparam int                DMA_ERR_POS  = 31;
    localparam int                HIPRI_POS    = 30;

    typedef enum logic [1:0] {
        SEL_PRIM   = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_DMA    = 2'd2,
        SEL_TIMING = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
// Sticky status bank with write-one-to-clear.
// Only bits in IMPL exist; a set on the same edge as a clear wins.
module irq_status_bank #(
    parameter int              W    = 32,
    parameter logic [W-1:0]    IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         clr_en,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] stat
);
    logic [W-1:0] clr_vec;

    // Clear vector only during a write to this bank.
    always_comb clr_vec = clr_en ? clr_data : '0;

    // Hold, clear on ones, then apply new sets.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= ((stat & ~clr_vec) | set) & IMPL;
    end

    // R1: without a clear write, no set bit drops.
    a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ((stat & $past(stat)) == $past(stat)));

    // R2: every implemented set lands, even under a clear.
    a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set & IMPL)) |=> ((stat & $past(set & IMPL)) == $past(set & IMPL)));
endmodule

// File: rtl/irq_prescale.sv
// Divides a microsecond tick into coarse units of UNIT_TICKS ticks.
// A restart clears the phase so the next unit is a full one.
module irq_prescale #(
    parameter int UNIT_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic unit
);
    localparam int PW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;

    logic [PW-1:0] phase;

    // Unit pulse on the last tick of each group.
    always_comb unit = tick && (phase == PW'(UNIT_TICKS - 1));

    // Phase counter over ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) phase <= '0;
        else if (tick)         phase <= unit ? '0 : phase + PW'(1);
    end
endmodule

// File: rtl/irq_coalesce.sv
// Coalescing window: idle -> counting -> open.
// Counting starts on a pending cause while idle. A host clear or the loss
// of all pending causes returns to idle. The window opens after len units.
module irq_coalesce #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend,
    input  logic             host_clr,
    input  logic             unit,
    input  logic [CNT_W-1:0] len,
    output logic             start,
    output logic             open
);
    logic             armed;
    logic             expired;
    logic [CNT_W-1:0] remain;

    // Begin a window only from idle with a cause waiting.
    always_comb start = !armed && !expired && pend && !host_clr;

    // Window is open when expired or coalescing is off.
    always_comb open = expired || (len == '0);

    // Window state and remaining unit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            expired <= 1'b0;
            remain  <= '0;
        end else if (host_clr || !pend) begin
            armed   <= 1'b0;
            expired <= 1'b0;
        end else if (start) begin
            armed   <= 1'b1;
            remain  <= len;
        end else if (armed && unit) begin
            if (remain <= CNT_W'(1)) begin
                armed   <= 1'b0;
                expired <= 1'b1;
            end else begin
                remain  <= remain - CNT_W'(1);
            end
        end
    end

    // R6: a counting window cannot open without a unit boundary.
    a_r6_no_early_open: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !unit) |=> !expired);

    // R7: a host clear always returns the timer to idle.
    a_r7_clear_idles: assert property (@(posedge clk) disable iff (!rst_n)
        host_clr |=> (!armed && !expired));
endmodule

// File: rtl/irq_aggregator.sv
// Interrupt aggregator top: primary and DMA status banks, mask, timing
// register, coalescing window, periodic poll timer and read mux.
// Assumes all inputs are synchronous to clk.
module irq_aggregator
    import irq_pkg::*;
#(
    parameter int UNIT_TICKS = 32,
    parameter int CNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_evt,
    input  logic [DATA_W-1:0] dma_evt,
    input  logic              tick_us,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int TIME_W = 2 * CNT_W;

    reg_sel_e          wsel;
    reg_sel_e          rsel;
    logic [DATA_W-1:0] prim_stat;
    logic [DATA_W-1:0] dma_stat;
    logic [DATA_W-1:0] prim_view;
    logic [DATA_W-1:0] prim_set;
    logic [DATA_W-1:0] mask_q;
    logic [TIME_W-1:0] timing_q;
    logic [CNT_W-1:0]  coal_len;
    logic [CNT_W-1:0]  poll_len;
    logic [CNT_W-1:0]  poll_cnt;
    logic              poll_unit;
    logic              poll_fire;
    logic              coal_unit;
    logic              coal_start;
    logic              coal_open;
    logic              host_clr;
    logic              pend;
    logic              bypass;

    // Decode selects and timing fields.
    always_comb begin
        wsel     = reg_sel_e'(wr_sel);
        rsel     = reg_sel_e'(rd_sel);
        coal_len = timing_q[CNT_W-1:0];
        poll_len = timing_q[TIME_W-1:CNT_W];
        host_clr = wr_en && (wsel == SEL_PRIM || wsel == SEL_DMA) && (|wr_data);
    end

    // Primary sets: direct sources plus the periodic poll bit.
    always_comb begin
        prim_set           = src_evt & DIRECT_BITS;
        prim_set[POLL_POS] = poll_fire;
    end

    irq_status_bank #(.W(DATA_W), .IMPL(PRIM_STICKY)) u_prim (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (prim_set),
        .clr_en   (wr_en && wsel == SEL_PRIM),
        .clr_data (wr_data),
        .stat     (prim_stat)
    );

    irq_status_bank #(.W(DATA_W), .IMPL(DMA_BITS)) u_dma (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (dma_evt),
        .clr_en   (wr_en && wsel == SEL_DMA),
        .clr_data (wr_data),
        .stat     (dma_stat)
    );

    // Fold DMA groups into the primary summary positions.
    always_comb begin
        prim_view              = prim_stat;
        prim_view[RX_SUM_POS]  = |{dma_stat[17:16], dma_stat[HIPRI_POS]};
        prim_view[ERR_SUM_POS] = dma_stat[DMA_ERR_POS];
        prim_view[TX_SUM_POS]  = |dma_stat[1:0];
    end

    // Mask and timing registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            timing_q <= '0;
        end else if (wr_en) begin
            if (wsel == SEL_MASK)   mask_q   <= wr_data;
            if (wsel == SEL_TIMING) timing_q <= wr_data[TIME_W-1:0];
        end
    end

    irq_prescale #(.UNIT_TICKS(UNIT_TICKS)) u_poll_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (1'b0),
        .tick    (tick_us),
        .unit    (poll_unit)
    );

    // Periodic poll fires on the last unit of each period.
    always_comb poll_fire = poll_unit && (poll_len != '0) &&
                            (poll_cnt >= poll_len - CNT_W'(1));

    // Periodic unit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || poll_len == '0) poll_cnt <= '0;
        else if (poll_unit)           poll_cnt <= poll_fire ? '0 : poll_cnt + CNT_W'(1);
    end

    // R9: with periodic off the counter rests at zero.
    a_r9_poll_off_rests: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_len == '0) |=> (poll_cnt == '0));

    irq_prescale #(.UNIT_TICKS(UNIT_TICKS)) u_coal_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (coal_start),
        .tick    (tick_us),
        .unit    (coal_unit)
    );

    irq_coalesce #(.CNT_W(CNT_W)) u_coal (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend),
        .host_clr (host_clr),
        .unit     (coal_unit),
        .len      (coal_len),
        .start    (coal_start),
        .open     (coal_open)
    );

    // Pending, bypass and the interrupt line.
    always_comb begin
        pend   = |(prim_view & mask_q);
        bypass = dma_stat[HIPRI_POS] && mask_q[RX_SUM_POS];
        irq    = bypass || (pend && coal_open);
    end

    // Register read mux.
    always_comb begin
        unique case (rsel)
            SEL_PRIM:   rd_data = prim_view;
            SEL_MASK:   rd_data = mask_q;
            SEL_DMA:    rd_data = dma_stat;
            SEL_TIMING: rd_data = DATA_W'(timing_q);
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: tb/irq_aggregator_tb.sv
// Bench for irq_aggregator: behavioural model stepped every clock,
// directed phases per requirement, then a mixed random phase.
module irq_aggregator_tb;
    localparam logic [31:0] DIRECT = 32'h0600_00CB;
    localparam logic [31:0] STICKY = 32'h1600_00CB;
    localparam logic [31:0] DMAB   = 32'hC003_0003;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src_evt, dma_evt, wr_data;
    logic        tick_us, wr_en, irq;
    logic [1:0]  wr_sel, rd_sel;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;

    always #4 clk = ~clk;

    irq_aggregator u_dut (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .dma_evt(dma_evt),
        .tick_us(tick_us), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    // Behavioural model state.
    logic [31:0] m_prim, m_dma, m_mask;
    logic [15:0] m_time;
    bit          m_armed, m_open;
    int          m_ticks, m_target, m_gpre, m_pc;

    function automatic logic [31:0] m_view();
        logic [31:0] v = m_prim;
        v[31] = m_dma[17] | m_dma[16] | m_dma[30];
        v[29] = m_dma[31];
        v[27] = m_dma[1] | m_dma[0];
        return v;
    endfunction

    function automatic logic m_irq();
        bit pend = |(m_view() & m_mask);
        return (m_dma[30] && m_mask[31]) || (pend && (m_open || m_time[7:0] == 0));
    endfunction

    function automatic logic [31:0] m_rd(input logic [1:0] s);
        case (s)
            2'd0: return m_view();
            2'd1: return m_mask;
            2'd2: return m_dma;
            default: return {16'h0, m_time};
        endcase
    endfunction

    // Model update on each rising edge from pre-edge values.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_prim = 0; m_dma = 0; m_mask = 0; m_time = 0;
            m_armed = 0; m_open = 0; m_ticks = 0; m_target = 0; m_gpre = 0; m_pc = 0;
        end else begin
            bit pend, clr, fire, unit_p;
            int plen, clen;
            logic [31:0] c0, c2;
            pend = |(m_view() & m_mask);
            clr  = wr_en && (wr_sel == 2'd0 || wr_sel == 2'd2) && wr_data != 0;
            plen = int'(m_time[15:8]);
            clen = int'(m_time[7:0]);
            if (clr || !pend) begin
                m_armed = 0; m_open = 0;
            end else if (!m_armed && !m_open) begin
                m_armed = 1; m_ticks = 0; m_target = (clen == 0 ? 1 : clen) * 32;
            end else if (m_armed && tick_us) begin
                m_ticks++;
                if (m_ticks >= m_target) begin m_armed = 0; m_open = 1; end
            end
            unit_p = tick_us && (m_gpre == 31);
            if (tick_us) m_gpre = (m_gpre + 1) % 32;
            fire = 0;
            if (plen == 0) m_pc = 0;
            else if (unit_p) begin
                if (m_pc >= plen - 1) begin fire = 1; m_pc = 0; end
                else m_pc++;
            end
            c0 = (wr_en && wr_sel == 2'd0) ? wr_data : 32'h0;
            c2 = (wr_en && wr_sel == 2'd2) ? wr_data : 32'h0;
            m_prim = ((m_prim & ~c0) | (src_evt & DIRECT) | (32'(fire) << 28)) & STICKY;
            m_dma  = ((m_dma & ~c2) | dma_evt) & DMAB;
            if (wr_en && wr_sel == 2'd1) m_mask = wr_data;
            if (wr_en && wr_sel == 2'd3) m_time = wr_data[15:0];
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        #1;
        if (cmp_on && rst_n) begin
            check("R5 R6 R8 irq vs model", {31'h0, irq}, {31'h0, m_irq()});
            check("R11 rd_data vs model", rd_data, m_rd(rd_sel));
        end
    end

    task automatic step();
        @(posedge clk); #1;
        src_evt = 0; dma_evt = 0; wr_en = 0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        wr_en = 1; wr_sel = s; wr_data = d; step();
    endtask

    task automatic chk_rd(input logic [1:0] s, input logic [31:0] exp, input string tag);
        rd_sel = s; @(negedge clk); check(tag, rd_data, exp);
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk); check(tag, {31'h0, irq}, {31'h0, exp});
    endtask

    bit done = 0;
    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; src_evt = 0; dma_evt = 0; tick_us = 0; wr_en = 0;
        wr_sel = 0; wr_data = 0; rd_sel = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1; cmp_on = 1;

        // R10 reset state
        chk_rd(2'd0, 32'h0, "R10 prim");
        chk_rd(2'd1, 32'h0, "R10 mask");
        chk_rd(2'd2, 32'h0, "R10 dma");
        chk_rd(2'd3, 32'h0, "R10 timing");
        chk_irq(1'b0, "R10 irq");

        // R11 readback
        wr(2'd1, 32'hFFFF_FFFF);
        chk_rd(2'd1, 32'hFFFF_FFFF, "R11 mask");
        wr(2'd3, 32'hABCD_1234);
        chk_rd(2'd3, 32'h0000_1234, "R11 timing");
        wr(2'd3, 32'h0);

        // R1 sticky and W1C, R6 with C=0
        src_evt = 32'h1; step();
        chk_irq(1'b1, "R6 immediate with C=0");
        chk_rd(2'd0, 32'h1, "R1 set");
        wr(2'd0, 32'h0);
        chk_rd(2'd0, 32'h1, "R1 write zero keeps");
        wr(2'd0, 32'h1);
        chk_rd(2'd0, 32'h0, "R1 write one clears");

        // R2 set wins
        src_evt = 32'h8; wr(2'd0, 32'h8);
        chk_rd(2'd0, 32'h8, "R2 set wins");
        wr(2'd0, 32'h8);

        // R4 summaries
        dma_evt = 32'h0001_0000; step();
        chk_rd(2'd0, 32'h8000_0000, "R4 rx summary");
        chk_rd(2'd2, 32'h0001_0000, "R4 dma bit16");
        wr(2'd0, 32'h8000_0000);
        chk_rd(2'd0, 32'h8000_0000, "R4 summary not writable");
        dma_evt = 32'h2; step();
        chk_rd(2'd0, 32'h8800_0000, "R4 tx summary");
        dma_evt = 32'h8000_0000; step();
        chk_rd(2'd0, 32'hA800_0000, "R4 err summary");
        wr(2'd2, 32'hFFFF_FFFF);
        chk_rd(2'd0, 32'h0, "R4 cleared via dma");

        // R3 implemented bits
        src_evt = 32'hFFFF_FFFF; dma_evt = 32'hFFFF_FFFF; step();
        chk_rd(2'd0, 32'hAE00_00CB, "R3 prim bits");
        chk_rd(2'd2, 32'hC003_0003, "R3 dma bits");
        wr(2'd0, 32'hFFFF_FFFF); wr(2'd2, 32'hFFFF_FFFF);
        chk_rd(2'd0, 32'h0, "R3 cleared");

        // R5 masking
        wr(2'd1, 32'h0);
        src_evt = 32'h1; step();
        chk_irq(1'b0, "R5 masked");
        wr(2'd1, 32'h1);
        chk_irq(1'b1, "R5 unmasked");
        wr(2'd0, 32'hFFFF_FFFF); wr(2'd1, 32'hFFFF_FFFF);

        // R6 window of 2 units
        wr(2'd3, 32'h0002); tick_us = 1;
        src_evt = 32'h0200_0000; step();
        repeat (40) step();
        chk_irq(1'b0, "R6 held during window");
        repeat (40) step();
        chk_irq(1'b1, "R6 open after window");

        // R7 clear reloads
        src_evt = 32'h40; step();
        wr(2'd0, 32'h0200_0000);
        chk_irq(1'b0, "R7 clear closes window");
        repeat (70) step();
        chk_irq(1'b1, "R7 new window opens");
        wr(2'd0, 32'hFFFF_FFFF);

        // R8 bypass
        dma_evt = 32'h4000_0000; step();
        chk_irq(1'b1, "R8 bypass immediate");
        chk_rd(2'd0, 32'h8000_0000, "R4 hipri in rx summary");
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd1, 32'h7FFF_FFFF);
        dma_evt = 32'h4000_0000; step();
        chk_irq(1'b0, "R8 bypass needs mask bit 31");
        wr(2'd2, 32'hFFFF_FFFF); wr(2'd1, 32'hFFFF_FFFF);

        // R9 periodic
        wr(2'd1, 32'h0); wr(2'd3, 32'h0300); wr(2'd0, 32'hFFFF_FFFF);
        repeat (140) step();
        chk_rd(2'd0, 32'h1000_0000, "R9 periodic sets bit 28");
        wr(2'd3, 32'h0); wr(2'd0, 32'hFFFF_FFFF);
        repeat (140) step();
        chk_rd(2'd0, 32'h0, "R9 periodic off");
        wr(2'd1, 32'hFFFF_FFFF);

        // Mixed random phase
        for (int i = 0; i < 4000; i++) begin
            src_evt = ($urandom_range(0, 9) == 0) ? $urandom : 32'h0;
            dma_evt = ($urandom_range(0, 14) == 0) ? $urandom : 32'h0;
            tick_us = 1'($urandom_range(0, 1));
            rd_sel  = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 7) == 0) begin
                wr_en  = 1;
                wr_sel = 2'($urandom_range(0, 3));
                if (wr_sel == 2'd3)
                    wr_data = {16'h0, 8'($urandom_range(0, 2)), 8'($urandom_range(0, 3))};
                else if (wr_sel == 2'd1)
                    wr_data = $urandom | 32'h8000_0000;
                else
                    wr_data = ($urandom_range(0, 1) == 0) ? 32'h0 : $urandom;
            end
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule